// File: doc/BRIEF.md
# Software Flow Control Character Monitor

This block watches the stream of characters coming out of a serial receiver. It checks each one against four programmable codes: two resume codes (XON1, XON2) and two pause codes (XOFF1, XOFF2). When a code from the active set arrives, the block pauses or releases the local transmitter through a single halt level. Every detected code, every received line break and every 9-bit multidrop address character is recorded in a sticky status byte. That byte is cleared by a one-cycle read strobe and can raise a maskable interrupt.

A 2-bit receive selector chooses which code pair controls the transmitter: the first pair, the second pair, both, or neither. A second 2-bit selector states which pairs the local transmitter is allowed to emit. That selector is decoded into two permission levels for the transmit path and has no other effect here. Assembling the characters is done upstream: this block sees only a character strobe, the character, an address flag and a break pulse.

Top module: `swfc_monitor`

## Requirements
- R1: After reset, and while reset is held, `tx_halt` is 0, `stat_byte` is 0x00 and `irq` is 0.
- R2: The receive selector `rx_fc_sel` enables the code pairs as follows. Value 01 enables XON2/XOFF2 only. Value 10 enables XON1/XOFF1 only. Value 11 enables all four codes. A character that matches only a code of a disabled pair changes neither `tx_halt` nor `stat_byte`.
- R3: A strobed character that matches an enabled pause code sets `tx_halt` at the next clock edge. One that matches an enabled resume code (and no enabled pause code) clears it at the next edge. In every other case with flow control on, `tx_halt` holds its value.
- R4: With `rx_fc_sel` = 00, `tx_halt` is 0 from the next edge on, whatever characters arrive, and no code status bit is set.
- R5: A character that matches both an enabled resume code and an enabled pause code sets `tx_halt`, so the pause wins. The status bits of both codes are set.
- R6: The status bits are: bit 0 XON1 seen, bit 1 XON2 seen, bit 2 XOFF1 seen, bit 3 XOFF2 seen, bit 4 break received, bit 5 address character received. Bits 7:6 always read 0. A set bit stays set until it is read.
- R7: A character strobed with `rx_addr` = 1 sets status bit 5. It is not compared with the codes, so `tx_halt` and bits 3:0 are unchanged.
- R8: A `stat_rd` pulse clears every status bit at the next edge. An event in the same cycle as the pulse is still recorded.
- R9: `irq` is 1 exactly while some status bit is 1 and the same bit of `irq_en` is 1.
- R10: `tx_fc_sel` is decoded into `gen_pair1` and `gen_pair2`: 00 gives neither, 01 gives pair 2 only, 10 gives pair 1 only, 11 gives both.
- R11: While `rx_valid` is 0, `rx_char` and `rx_addr` have no effect on `tx_halt` or `stat_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_char | input | CHAR_W | Received character |
| rx_addr | input | 1 | Strobed character is a 9-bit multidrop address |
| rx_break | input | 1 | One-cycle pulse: line break received |
| xon1_code | input | CHAR_W | First resume code |
| xon2_code | input | CHAR_W | Second resume code |
| xoff1_code | input | CHAR_W | First pause code |
| xoff2_code | input | CHAR_W | Second pause code |
| rx_fc_sel | input | 2 | Which received codes control the transmitter |
| tx_fc_sel | input | 2 | Which code pairs the local transmitter may emit |
| stat_rd | input | 1 | One-cycle status read strobe (clears status) |
| irq_en | input | STAT_W | Per-bit interrupt enables |
| tx_halt | output | 1 | Transmitter pause request |
| stat_byte | output | STAT_W | Sticky special-character status |
| irq | output | 1 | Interrupt request |
| gen_pair1 | output | 1 | Transmitter may emit XON1/XOFF1 |
| gen_pair2 | output | 1 | Transmitter may emit XON2/XOFF2 |

## Verification
The embedded properties assume that every input is known and settled at each rising edge. They also assume that the strobes `rx_valid`, `rx_break` and `stat_rd` are synchronous levels sampled once per edge, with no meaning carried between edges. The bench drives every input on the falling edge and deasserts each strobe one cycle after raising it. It changes the code registers only between characters, so no comparison straddles a code update.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

  // Number of programmable special codes: index 0 XON1, 1 XON2, 2 XOFF1, 3 XOFF2
  localparam int unsigned NUM_SPC = 4;
  // Event bits recorded in the status byte: four codes, break, address
  localparam int unsigned NUM_EV  = NUM_SPC + 2;
  localparam int unsigned IDX_BRK = NUM_SPC;
  localparam int unsigned IDX_ADR = NUM_SPC + 1;

  localparam logic [NUM_SPC-1:0] RESUME_MASK = 4'b0011;
  localparam logic [NUM_SPC-1:0] PAUSE_MASK  = 4'b1100;

  typedef enum logic [1:0] {
    FC_NONE  = 2'b00,
    FC_PAIR2 = 2'b01,
    FC_PAIR1 = 2'b10,
    FC_BOTH  = 2'b11
  } fc_sel_e;

  // Selector bit 1 enables pair 1 (indices 0 and 2), bit 0 enables pair 2 (1 and 3)
  function automatic logic [NUM_SPC-1:0] pair_mask(input logic [1:0] sel);
    pair_mask = {sel[0], sel[1], sel[0], sel[1]};
  endfunction

endpackage

// File: rtl/swfc_char_match.sv
module swfc_char_match
  import swfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic                      rx_valid_i,
  input  logic                      rx_addr_i,
  input  logic [CHAR_W-1:0]         rx_char_i,
  input  logic [NUM_SPC*CHAR_W-1:0] codes_i,
  input  logic [1:0]                sel_i,
  output logic [NUM_SPC-1:0]        hit_o
);

  logic [NUM_SPC-1:0] raw_eq;

  generate
    for (genvar g = 0; g < NUM_SPC; g++) begin : g_cmp
      assign raw_eq[g] = (rx_char_i == codes_i[g*CHAR_W +: CHAR_W]);
    end
  endgenerate

  always_comb begin
    if (rx_valid_i && !rx_addr_i) begin
      hit_o = raw_eq & pair_mask(sel_i);
    end else begin
      hit_o = '0;
    end
  end

endmodule

// File: rtl/swfc_halt_ctl.sv
module swfc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fc_on_i,
  input  logic resume_hit_i,
  input  logic pause_hit_i,
  output logic halt_o
);

  logic halt_q;
  logic halt_d;
  logic halt_en;

  always_comb begin
    halt_en = !fc_on_i || resume_hit_i || pause_hit_i;
    halt_d  = halt_q;
    if (!fc_on_i) begin
      halt_d = 1'b0;
    end else if (pause_hit_i) begin
      halt_d = 1'b1;
    end else if (resume_hit_i) begin
      halt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (halt_en) begin
      halt_q <= halt_d;
    end
  end

  assign halt_o = halt_q;

  // R3 R5
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on_i && pause_hit_i) |=> halt_o);

  // R3
  halt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on_i && resume_hit_i && !pause_hit_i) |=> !halt_o);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on_i && !resume_hit_i && !pause_hit_i) |=> (halt_o == $past(halt_o)));

  // R4
  halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_on_i |=> !halt_o);

endmodule

// File: rtl/swfc_status_reg.sv
module swfc_status_reg #(
  parameter int unsigned STAT_W = 8,
  parameter int unsigned EV_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [EV_W-1:0]   ev_i,
  output logic [STAT_W-1:0] stat_o
);

  localparam int unsigned PAD_W = STAT_W - EV_W;

  logic [EV_W-1:0] flag_q;
  logic [EV_W-1:0] flag_d;
  logic            flag_en;

  always_comb begin
    flag_en = rd_i || (|ev_i);
    flag_d  = (flag_q & {EV_W{~rd_i}}) | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign stat_o = {{PAD_W{1'b0}}, flag_q};

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (ev_i == '0)) |=> (stat_o == '0));

  // R8
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ((stat_o[EV_W-1:0] & $past(ev_i)) == $past(ev_i)));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

endmodule

// File: rtl/swfc_monitor.sv
module swfc_monitor
  import swfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_addr,
  input  logic              rx_break,
  input  logic [CHAR_W-1:0] xon1_code,
  input  logic [CHAR_W-1:0] xon2_code,
  input  logic [CHAR_W-1:0] xoff1_code,
  input  logic [CHAR_W-1:0] xoff2_code,
  input  logic [1:0]        rx_fc_sel,
  input  logic [1:0]        tx_fc_sel,
  input  logic              stat_rd,
  input  logic [STAT_W-1:0] irq_en,
  output logic              tx_halt,
  output logic [STAT_W-1:0] stat_byte,
  output logic              irq,
  output logic              gen_pair1,
  output logic              gen_pair2
);

  logic [NUM_SPC*CHAR_W-1:0] codes;
  logic [NUM_SPC-1:0]        hit;
  logic                      fc_on;
  logic                      resume_hit;
  logic                      pause_hit;
  logic [NUM_EV-1:0]         ev;

  assign codes = {xoff2_code, xoff1_code, xon2_code, xon1_code};

  swfc_char_match #(
    .CHAR_W (CHAR_W)
  ) i_match (
    .rx_valid_i (rx_valid),
    .rx_addr_i  (rx_addr),
    .rx_char_i  (rx_char),
    .codes_i    (codes),
    .sel_i      (rx_fc_sel),
    .hit_o      (hit)
  );

  always_comb begin
    fc_on       = (rx_fc_sel != FC_NONE);
    resume_hit  = |(hit & RESUME_MASK);
    pause_hit   = |(hit & PAUSE_MASK);
    ev          = '0;
    ev[NUM_SPC-1:0] = hit;
    ev[IDX_BRK] = rx_break;
    ev[IDX_ADR] = rx_valid && rx_addr;
  end

  swfc_halt_ctl i_halt (
    .clk          (clk),
    .rst_n        (rst_n),
    .fc_on_i      (fc_on),
    .resume_hit_i (resume_hit),
    .pause_hit_i  (pause_hit),
    .halt_o       (tx_halt)
  );

  swfc_status_reg #(
    .STAT_W (STAT_W),
    .EV_W   (NUM_EV)
  ) i_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (stat_rd),
    .ev_i   (ev),
    .stat_o (stat_byte)
  );

  assign irq = |(stat_byte & irq_en);

  always_comb begin
    gen_pair1 = 1'b0;
    gen_pair2 = 1'b0;
    case (fc_sel_e'(tx_fc_sel))
      FC_NONE:  ;
      FC_PAIR2: gen_pair2 = 1'b1;
      FC_PAIR1: gen_pair1 = 1'b1;
      default: begin
        gen_pair1 = 1'b1;
        gen_pair2 = 1'b1;
      end
    endcase
  end

  // R7
  addr_no_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_addr && fc_on) |=> (tx_halt == $past(tx_halt)));

  // R7
  addr_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_addr && !stat_rd) |=> (stat_byte[NUM_SPC-1:0] == $past(stat_byte[NUM_SPC-1:0])));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && fc_on) |=> (tx_halt == $past(tx_halt)));

endmodule

// File: tb/test_swfc_monitor.sv
`timescale 1ns/1ps
module test_swfc_monitor;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_addr, rx_break, stat_rd;
  logic [7:0] rx_char, xon1_code, xon2_code, xoff1_code, xoff2_code, irq_en;
  logic [1:0] rx_fc_sel, tx_fc_sel;
  logic       tx_halt, irq, gen_pair1, gen_pair2;
  logic [7:0] stat_byte;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  swfc_monitor i_swfc_monitor (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_addr(rx_addr), .rx_break(rx_break), .xon1_code(xon1_code),
    .xon2_code(xon2_code), .xoff1_code(xoff1_code), .xoff2_code(xoff2_code),
    .rx_fc_sel(rx_fc_sel), .tx_fc_sel(tx_fc_sel), .stat_rd(stat_rd),
    .irq_en(irq_en), .tx_halt(tx_halt), .stat_byte(stat_byte), .irq(irq),
    .gen_pair1(gen_pair1), .gen_pair2(gen_pair2)
  );

  // Vector: {sel[21:20], char[19:12], addr[11], brk[10], rd[9], exp_halt[8], exp_stat[7:0]}
  // Codes: XON1=11 XON2=12 XOFF1=13 XOFF2=14
  localparam int NVEC = 19;
  localparam logic [21:0] VEC [NVEC] = '{
    {2'b10, 8'h13, 1'b0, 1'b0, 1'b1, 1'b1, 8'h04},  // R2 R3 pair1 pause
    {2'b10, 8'h14, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},  // R2 pair2 code ignored
    {2'b10, 8'h12, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},  // R2
    {2'b10, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01},  // R3 resume
    {2'b01, 8'h13, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R2
    {2'b01, 8'h14, 1'b0, 1'b0, 1'b1, 1'b1, 8'h08},  // R2 R3
    {2'b01, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},  // R2
    {2'b01, 8'h12, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02},  // R3
    {2'b11, 8'h13, 1'b0, 1'b0, 1'b1, 1'b1, 8'h04},  // R2 both pairs
    {2'b11, 8'h12, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02},
    {2'b11, 8'h14, 1'b0, 1'b0, 1'b1, 1'b1, 8'h08},
    {2'b11, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01},
    {2'b11, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R3 no match holds
    {2'b11, 8'h13, 1'b0, 1'b1, 1'b0, 1'b1, 8'h14},  // R6 break + pause
    {2'b11, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h15},  // R6 sticky
    {2'b11, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 8'h20},  // R7 address not compared
    {2'b11, 8'h13, 1'b0, 1'b0, 1'b1, 1'b1, 8'h04},
    {2'b00, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R4 off clears halt
    {2'b00, 8'h13, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}   // R4 codes ignored
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] sel, input logic [7:0] ch, input logic v,
                      input logic a, input logic b, input logic r);
    @(negedge clk);
    rx_fc_sel = sel; rx_char = ch; rx_valid = v; rx_addr = a; rx_break = b; stat_rd = r;
    @(negedge clk);
    rx_valid = 1'b0; rx_addr = 1'b0; rx_break = 1'b0; stat_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_addr = 1'b0; rx_break = 1'b0; stat_rd = 1'b0;
    rx_char = 8'h00; rx_fc_sel = 2'b00; tx_fc_sel = 2'b00; irq_en = 8'hFF;
    xon1_code = 8'h11; xon2_code = 8'h12; xoff1_code = 8'h13; xoff2_code = 8'h14;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 halt", {7'd0, tx_halt}, 8'h00);
    chk("R1 stat", stat_byte, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    irq_en = 8'h00;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21:20], VEC[i][19:12], 1'b1, VEC[i][11], VEC[i][10], VEC[i][9]);
      chk($sformatf("R2/R3/R4/R6/R7 vec%0d halt", i), {7'd0, tx_halt}, {7'd0, VEC[i][8]});
      chk($sformatf("R6/R8 vec%0d stat", i), stat_byte, VEC[i][7:0]);
    end

    // R11 character without strobe ignored
    step(2'b11, 8'h13, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11 halt", {7'd0, tx_halt}, 8'h00);
    chk("R11 stat", stat_byte, 8'h00);

    // R5 same code as resume and pause: pause wins
    xoff1_code = 8'h11;
    step(2'b11, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R5 halt", {7'd0, tx_halt}, 8'h01);
    chk("R5 stat", stat_byte, 8'h05);
    xoff1_code = 8'h13;
    step(2'b11, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R3 resume after R5", {7'd0, tx_halt}, 8'h00);

    // R8 read with simultaneous event, then plain read
    step(2'b11, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 event wins", stat_byte, 8'h10);
    step(2'b11, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 clear", stat_byte, 8'h00);
    step(2'b11, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    step(2'b11, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 sticky break", stat_byte, 8'h10);

    // R9 interrupt masking
    irq_en = 8'h10; #1;
    chk("R9 enabled", {7'd0, irq}, 8'h01);
    irq_en = 8'hEF; #1;
    chk("R9 masked", {7'd0, irq}, 8'h00);

    // R10 transmit selector decode
    for (int s = 0; s < 4; s++) begin
      tx_fc_sel = s[1:0]; #1;
      chk($sformatf("R10 sel%0d", s), {6'd0, gen_pair1, gen_pair2}, {6'd0, s[1:0]});
    end

    // R4 disable while halted, no character
    step(2'b11, 8'h14, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R4 precondition halt", {7'd0, tx_halt}, 8'h01);
    step(2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 disable clears", {7'd0, tx_halt}, 8'h00);

    // R1 asynchronous reset mid-run
    step(2'b11, 8'h13, 1'b1, 1'b0, 1'b1, 1'b0);
    #1 rst_n = 1'b0; #1;
    chk("R1 async halt", {7'd0, tx_halt}, 8'h00);
    chk("R1 async stat", stat_byte, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule